// File: doc/BRIEF.md
# Select-Driven Frequency Slew Controller

This block computes the frequency word for the processor clock synthesizer. A three-bit select input picks one of eight target frequencies from a table fixed at build time. The output is never loaded with a new target in one jump. It walks toward the new target in bounded increments, one increment per timebase tick, so that loops locked further down the clock tree can follow the change. Frequencies are integers in kHz. Every table entry is first forced into the allowed window: 8 MHz at the bottom, and the configured maximum output frequency at the top.

A new select value takes effect only after it has been seen unchanged on several consecutive ticks. Until then the previous frequency is held. A short glitch on the select lines therefore never disturbs the output. A new request that arrives during a ramp takes over from the value reached so far, without a jump. A build option changes the meaning of the top select bit: it becomes a power-management input elsewhere, and only the two low bits choose among the first four table entries. A settled flag shows whether the output has reached the target currently in force.

Top module: `freq_slew_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, freqKhz equals the clamped table entry for code 0, the code in force is 0, and settled is 1.
- R2: In normal mode, the code in force is all three select bits read as an unsigned number. Code c selects table entry c, which is stored at bits [c*FW +: FW] of TARGETS. Once the ramp ends, freqKhz equals that entry after clamping.
- R3: A table entry below MIN_KHZ (8000) is used as MIN_KHZ, and an entry above MAX_KHZ is used as MAX_KHZ. freqKhz never leaves [MIN_KHZ, MAX_KHZ].
- R4: The step is STEP_KHZ = RATE_KHZ_PER_US*TICK_NS/1000, with a minimum of 1. At each clock edge that samples tick=1, freqKhz moves toward the target by min(STEP_KHZ, distance). At an edge with tick=0 it does not change.
- R5: A select value is adopted only after it has been sampled unchanged on HOLD_TICKS consecutive ticks. The new target is loaded at the clock edge after the last of these ticks. Until that edge the old target stays in force. A tick that falls on the loading edge still steps toward the old target.
- R6: A new select value adopted during a ramp moves the ramp to the new target from the current value, with no jump larger than STEP_KHZ.
- R7: settled is 1 exactly when freqKhz equals the target in force.
- R8: With SUSPEND_MODE=1, select bit 2 has no effect, and the code in force is {0, selIn[1:0]}.
- R9: A select value that differs from the current value on fewer than HOLD_TICKS consecutive ticks, and then returns to it, leaves freqKhz and settled unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 3 | Frequency select code |
| tick | input | 1 | Timebase pulse; one step of slew is allowed per pulse |
| freqKhz | output | FW | Current frequency word in kHz |
| settled | output | 1 | Output equals the target in force |

## Verification
The bench builds the block with a 60 MHz ceiling, a 1000 kHz step (a 50 µs tick at 20 MHz/ms) and a hold of three ticks. With these values every ramp lasts at most 52 ticks, so all 64 ordered code transitions can be swept in full, and each one is compared cycle by cycle against an arithmetic model. The table holds one entry below the floor, one above the ceiling, one just under the ceiling, and one entry that is not a multiple of the step, so clamping and the shortened final step are both exercised. A second instance, built in suspend mode, is driven with select codes that differ only in bit 2. Further phases cover sparse ticks, a select glitch shorter than the hold, and a change of target in the middle of a ramp.

// File: rtl/slew_pkg.sv
package slew_pkg;
  localparam int SEL_W = 3;
  localparam int NCODE = 1 << SEL_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadTgt;
    logic [SEL_W-1:0] code;
    logic             stepEn;
  } slewCmd_t;
endpackage

// File: rtl/slew_ctl.sv
module slew_ctl import slew_pkg::*; #(
  parameter int HOLD_TICKS   = 3,
  parameter bit SUSPEND_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             tick,
  output slewCmd_t         cmd
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);

  logic [SEL_W-1:0] effCode, candCode, liveCode;
  logic [CW-1:0]    stableCnt;
  logic             adopt;

  // in suspend mode the top select bit is masked off
  assign effCode = {selIn[SEL_W-1] & ~SUSPEND_MODE, selIn[SEL_W-2:0]};
  assign adopt   = (stableCnt == HOLD_C) && (candCode != liveCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candCode  <= '0;
      liveCode  <= '0;
      stableCnt <= HOLD_C;
    end else begin
      if (adopt) liveCode <= candCode;
      if (tick) begin
        if (effCode != candCode) begin
          candCode  <= effCode;
          stableCnt <= CW'(1);
        end else if (stableCnt != HOLD_C) begin
          stableCnt <= stableCnt + CW'(1);
        end
      end
    end
  end

  assign cmd.loadTgt = adopt;
  assign cmd.code    = candCode;
  assign cmd.stepEn  = tick;
endmodule

// File: rtl/slew_dp.sv
module slew_dp import slew_pkg::*; #(
  parameter int FW       = 17,
  parameter int MIN_KHZ  = 8000,
  parameter int MAX_KHZ  = 100000,
  parameter int STEP_KHZ = 20,
  parameter logic [NCODE*FW-1:0] TARGETS = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  slewCmd_t      cmd,
  output logic [FW-1:0] freqKhz,
  output logic          settled
);
  localparam logic [FW-1:0] STEP_W = FW'(STEP_KHZ);

  logic [FW-1:0] clampTab [NCODE];
  logic [FW-1:0] curR, tgtR, gap, mv, nxt;
  logic          goUp;

  for (genvar i = 0; i < NCODE; i++) begin : g_tab
    localparam int RAW = int'(TARGETS[i*FW +: FW]);
    localparam int LIM = (RAW < MIN_KHZ) ? MIN_KHZ : ((RAW > MAX_KHZ) ? MAX_KHZ : RAW);
    assign clampTab[i] = FW'(LIM);
  end

  always_comb begin
    goUp = tgtR > curR;
    gap  = goUp ? (tgtR - curR) : (curR - tgtR);
    mv   = (gap > STEP_W) ? STEP_W : gap;
    nxt  = goUp ? (curR + mv) : (curR - mv);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curR <= clampTab[0];
      tgtR <= clampTab[0];
    end else begin
      if (cmd.stepEn)  curR <= nxt;
      if (cmd.loadTgt) tgtR <= clampTab[cmd.code];
    end
  end

  assign freqKhz = curR;
  assign settled = (curR == tgtR);
endmodule

// File: rtl/freq_slew_ctrl.sv
module freq_slew_ctrl import slew_pkg::*; #(
  parameter int FW               = 17,
  parameter int MIN_KHZ          = 8000,
  parameter int MAX_KHZ          = 100000,
  parameter int RATE_KHZ_PER_US  = 20,
  parameter int TICK_NS          = 1000,
  parameter int HOLD_TICKS       = 3,
  parameter bit SUSPEND_MODE     = 1'b0,
  parameter logic [NCODE*FW-1:0] TARGETS = {17'd100000, 17'd90000, 17'd80000, 17'd66000,
                                            17'd50000, 17'd33000, 17'd25000, 17'd16000}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             tick,
  output logic [FW-1:0]    freqKhz,
  output logic             settled
);
  localparam int STEP_RAW = RATE_KHZ_PER_US * TICK_NS / 1000;
  localparam int STEP_KHZ = (STEP_RAW < 1) ? 1 : STEP_RAW;

  slewCmd_t cmd;

  slew_ctl #(.HOLD_TICKS(HOLD_TICKS), .SUSPEND_MODE(SUSPEND_MODE)) ctl_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .tick(tick), .cmd(cmd));

  slew_dp #(.FW(FW), .MIN_KHZ(MIN_KHZ), .MAX_KHZ(MAX_KHZ),
            .STEP_KHZ(STEP_KHZ), .TARGETS(TARGETS)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .freqKhz(freqKhz), .settled(settled));
endmodule

// File: rtl/freq_slew_chk.sv
module freq_slew_chk #(
  parameter int FW       = 17,
  parameter int MIN_KHZ  = 8000,
  parameter int MAX_KHZ  = 100000,
  parameter int STEP_KHZ = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          tick,
  input logic [FW-1:0] freqKhz,
  input logic          settled
);
  localparam logic [FW-1:0] STEP_W = FW'(STEP_KHZ);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((freqKhz >= $past(freqKhz)) ? (freqKhz - $past(freqKhz) <= STEP_W)
                                          : ($past(freqKhz) - freqKhz <= STEP_W)));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(freqKhz));

  // R3
  window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(freqKhz) >= MIN_KHZ) && (int'(freqKhz) <= MAX_KHZ));

  // R7
  settled_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    settled |=> $stable(freqKhz));
endmodule

bind freq_slew_ctrl freq_slew_chk #(
  .FW(FW), .MIN_KHZ(MIN_KHZ), .MAX_KHZ(MAX_KHZ), .STEP_KHZ(STEP_KHZ)
) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .freqKhz(freqKhz), .settled(settled));

// File: tb/freq_slew_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_slew_ctrl_tb_top;
  localparam int FW = 17, MINK = 8000, MAXK = 60000, HOLD = 3, STEP = 1000;
  localparam logic [8*FW-1:0] TAB = {17'd59999, 17'd12000, 17'd45250, 17'd8000,
                                     17'd33500, 17'd75000, 17'd3000, 17'd20000};

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic [2:0] sel = 3'd0, susSel = 3'd0;
  logic [FW-1:0] freq, susFreq;
  logic settled, susSettled;
  int errors = 0, checks = 0, tickDiv = 1, tickCnt = 0;
  bit chkOn = 0, finished = 0;
  string curReq = "R2";

  always #2 clk = ~clk;

  freq_slew_ctrl #(.FW(FW), .MIN_KHZ(MINK), .MAX_KHZ(MAXK), .RATE_KHZ_PER_US(20),
    .TICK_NS(50000), .HOLD_TICKS(HOLD), .SUSPEND_MODE(1'b0), .TARGETS(TAB)) dut_i (
    .clk(clk), .rstN(rstN), .selIn(sel), .tick(tick), .freqKhz(freq), .settled(settled));

  freq_slew_ctrl #(.FW(FW), .MIN_KHZ(MINK), .MAX_KHZ(MAXK), .RATE_KHZ_PER_US(20),
    .TICK_NS(50000), .HOLD_TICKS(HOLD), .SUSPEND_MODE(1'b1), .TARGETS(TAB)) dutSus_i (
    .clk(clk), .rstN(rstN), .selIn(susSel), .tick(tick), .freqKhz(susFreq), .settled(susSettled));

  function automatic int expClamp(input int c);
    int raw = int'(TAB[c*FW +: FW]);
    return (raw < MINK) ? MINK : ((raw > MAXK) ? MAXK : raw);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // arithmetic model built from R4/R5 timing
  int mCur, mTgt, mCand, mLive, mCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      mCur = expClamp(0); mTgt = mCur; mCand = 0; mLive = 0; mCnt = HOLD;
    end else begin
      if (tick) begin
        if (mTgt > mCur) mCur = (mTgt - mCur > STEP) ? mCur + STEP : mTgt;
        else if (mTgt < mCur) mCur = (mCur - mTgt > STEP) ? mCur - STEP : mTgt;
      end
      if (mCnt == HOLD && mCand != mLive) begin
        mTgt = expClamp(mCand); mLive = mCand;
      end
      if (tick) begin
        if (int'(sel) != mCand) begin mCand = int'(sel); mCnt = 1; end
        else if (mCnt < HOLD) mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      check(int'(freq) == mCur, curReq, int'(freq), mCur);
      check(settled == (mCur == mTgt), {curReq, "/R7 settled"}, int'(settled), int'(mCur == mTgt));
    end
    if (rstN && tickCnt >= tickDiv - 1) begin tick = 1'b1; tickCnt = 0; end
    else begin tick = 1'b0; if (rstN) tickCnt++; end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int oldF, prev, d, maxD;
    waitCyc(4);
    // R1 during reset
    check(int'(freq) == 20000 && settled, "R1", int'(freq), 20000);
    check(int'(susFreq) == 20000 && susSettled, "R1", int'(susFreq), 20000);
    rstN = 1'b1;
    waitCyc(1);
    check(int'(freq) == 20000 && settled, "R1", int'(freq), 20000);
    chkOn = 1;

    // R8: suspend-mode instance ignores bit 2
    susSel = 3'b100; waitCyc(80);
    check(int'(susFreq) == 20000 && susSettled, "R8", int'(susFreq), 20000);
    susSel = 3'b111; waitCyc(80);
    check(int'(susFreq) == 33500, "R8", int'(susFreq), 33500);
    susSel = 3'b011; waitCyc(80);
    check(int'(susFreq) == 33500, "R8", int'(susFreq), 33500);
    susSel = 3'b110; waitCyc(80);
    check(int'(susFreq) == 60000, "R8", int'(susFreq), 60000);

    // R2/R3/R4/R5: every ordered transition
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        curReq = "R2";
        sel = 3'(a); waitCyc(70);
        oldF = int'(freq);
        sel = 3'(b);
        waitCyc(HOLD + 1);
        check(int'(freq) == oldF, "R5", int'(freq), oldF);
        maxD = 0;
        for (int k = 0; k < 60; k++) begin
          prev = int'(freq); waitCyc(1);
          d = (int'(freq) > prev) ? int'(freq) - prev : prev - int'(freq);
          if (d > maxD) maxD = d;
        end
        check(maxD <= STEP, "R4", maxD, STEP);
        if (a == 4 && b == 7) check(maxD == STEP, "R4", maxD, STEP);
        waitCyc(6);
        check(int'(freq) == expClamp(b) && settled,
              (b == 1 || b == 2) ? "R3" : "R2", int'(freq), expClamp(b));
      end
    end

    // R4: sparse ticks
    curReq = "R4"; tickDiv = 3;
    sel = 3'd4; waitCyc(200);
    sel = 3'd2; waitCyc(200);
    check(int'(freq) == 60000, "R4", int'(freq), 60000);
    tickDiv = 1;

    // R9: glitch shorter than the hold
    curReq = "R9";
    sel = 3'd0; waitCyc(80);
    sel = 3'd5; waitCyc(2);
    sel = 3'd0; waitCyc(30);
    check(int'(freq) == 20000 && settled, "R9", int'(freq), 20000);

    // R6: retarget mid-ramp
    curReq = "R6";
    sel = 3'd1; waitCyc(80);
    sel = 3'd2; waitCyc(HOLD + 16);
    check(!settled, "R7", int'(settled), 0);
    sel = 3'd0; waitCyc(80);
    check(int'(freq) == 20000 && settled, "R6", int'(freq), 20000);

    chkOn = 0;
    finish_run();
  end
endmodule